// File: doc/BRIEF.md
# Per-Pin Input Debounce Bank

This block filters the inputs of a bank of general-purpose pins before they reach the interrupt detector. Each pin can be left unfiltered, or it can be filtered. A filtered pin takes a new level only after two consecutive samples agree. A pin samples either on every clock or on a slow tick. The tick comes from one programmable divider that all pins share. The divider period is 2×(D+1) source clock cycles, where D is a 24-bit value. Software picks D as round(t_us × f_hz / 2e6) − 1 for a wanted time t in microseconds, so the longest period is 2^25 cycles.

Configuration arrives on a simple write port. The per-pin enable and tick-select bits are written sixteen pins at a time. Each such word carries a write mask in its upper half and bit values in its lower half, so one pin can be changed without a read-modify-write. The divider value is a plain word. Inputs are assumed to be already synchronised to `clk`.

Top module: `pin_debounce_bank`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pin_filt` equals `pin_raw` on every pin, so reset creates no edge.
- R2: A pin whose enable bit is 0 drives `pin_raw` straight to `pin_filt` in the same cycle, without a register in the path.
- R3: An enabled pin with select bit 0 samples on every clock edge. Its output takes a new input level at the second edge that sees that level. A level that is present at only one edge is never passed.
- R4: An enabled pin with select bit 1 samples only at tick edges. After a divider write at edge W, ticks fall at edges W+n·2(D+1) for n ≥ 1. An input change made just after W therefore appears on the output right after edge W+4(D+1), and not earlier.
- R5: A divider write restarts the tick count at once, whatever the phase of the count before the write.
- R6: Address s (0 ≤ s < NUM_PINS/16) holds the enable bits of pins 16s..16s+15. Address NUM_PINS/16+s holds their select bits. In a write, data bit 16+i is the mask for pin 16s+i and data bit i is its new value. A pin whose mask bit is 0 keeps its setting.
- R7: Address 2·NUM_PINS/16 holds the divider value D, taken from data bits 23:0. Data bits 31:24 are ignored.
- R8: Each pin filters on its own enable and select bits. Pins on the tick and pins on the raw clock can be mixed in one bank.
- R9: After reset every enable bit is 0, every select bit is 0 and D is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for the divider and the filters |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| pin_raw | input | NUM_PINS | Synchronised pin inputs |
| pin_filt | output | NUM_PINS | Filtered pin levels for the interrupt detector |

## Verification
The hardest case to reach is tick timing measured from a divider write. Only the filter outputs can show a tick, so the phase of the count has to be inferred. The bench first holds the inputs long enough for every sample to settle. It then writes a divider value, with junk in the ignored upper bits, and flips the inputs on the next cycle. The output must hold for 4(D+1)−1 edges and change on the following one. A long random run, which mixes reconfiguration, divider rewrites at arbitrary phases and short glitches, is compared every cycle against a model of the requirements.

// File: rtl/pdb_pkg.sv
// Shared constants for the pin debounce bank.
// Assumes the pin count is a multiple of the slice width.
package pdb_pkg;
    localparam int SLICE_W  = 16;   // pins covered by one masked config word
    localparam int WDATA_W  = 32;   // configuration data width
    localparam int MASK_LSB = 16;   // first mask bit inside a masked word
endpackage

// File: rtl/pdb_cfg_regs.sv
// Configuration store: per-pin enable and tick-select bits written
// through masked half-words, and a plain divider word.
// Assumes NUM_PINS is a multiple of pdb_pkg::SLICE_W.
module pdb_cfg_regs #(
    parameter int NUM_PINS = 32,
    parameter int DIV_W    = 24,
    parameter int ADDR_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [pdb_pkg::WDATA_W-1:0] wdata,
    output logic [NUM_PINS-1:0]         en_q,
    output logic [NUM_PINS-1:0]         sel_q,
    output logic [DIV_W-1:0]            div_q,
    output logic                        div_wr
);
    import pdb_pkg::*;

    localparam int SLICES   = NUM_PINS / SLICE_W;
    localparam int SEL_BASE = SLICES;
    localparam int DIV_ADDR = 2 * SLICES;

    logic [SLICE_W-1:0] wmask;
    logic [SLICE_W-1:0] wval;

    assign wmask  = wdata[MASK_LSB +: SLICE_W];
    assign wval   = wdata[SLICE_W-1:0];
    assign div_wr = we && (int'(addr) == DIV_ADDR);

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        logic en_hit;
        logic sel_hit;
        assign en_hit  = we && (int'(addr) == s);
        assign sel_hit = we && (int'(addr) == SEL_BASE + s);

        // Enable slice: masked bits take the new value, others hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[s*SLICE_W +: SLICE_W] <= '0;
            else if (en_hit)
                en_q[s*SLICE_W +: SLICE_W] <= (en_q[s*SLICE_W +: SLICE_W] & ~wmask)
                                            | (wval & wmask);
        end

        // Select slice: same masked update as the enable slice.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[s*SLICE_W +: SLICE_W] <= '0;
            else if (sel_hit)
                sel_q[s*SLICE_W +: SLICE_W] <= (sel_q[s*SLICE_W +: SLICE_W] & ~wmask)
                                             | (wval & wmask);
        end

        // R6: a write with an all-zero mask leaves the slice untouched
        a_r6_zero_mask_en: assert property (@(posedge clk) disable iff (!rst_n)
            (en_hit && wmask == '0) |=> $stable(en_q[s*SLICE_W +: SLICE_W]));
        a_r6_zero_mask_sel: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_hit && wmask == '0) |=> $stable(sel_q[s*SLICE_W +: SLICE_W]));
    end

    // Divider word: low DIV_W bits are stored and the rest is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_wr)
            div_q <= wdata[DIV_W-1:0];
    end
endmodule

// File: rtl/pdb_tick_gen.sv
// Shared debounce tick: one-cycle pulse every 2*(div_val+1) clocks.
// A restart pulse zeroes the count so the phase follows the last write.
module pdb_tick_gen #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             restart,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = {div_val, 1'b1};
    assign tick  = (cnt_q == limit);

    // Period counter: clears on restart or at its limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || cnt_q >= limit)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R4: the shortest period is two cycles, so ticks never touch
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R5: after a restart the count starts over and cannot tick at once
    a_r5_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    // R4: with no restart, the count stays within its period
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(div_val) |-> (cnt_q <= limit));
endmodule

// File: rtl/pdb_pin_filter.sv
// One pin's debounce filter. The pin samples on every clock or on the
// shared tick. The stored level follows the input only when two
// consecutive samples agree. A disabled pin is passed through unchanged.
module pdb_pin_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic en,
    input  logic use_tick,
    input  logic tick,
    output logic filt
);
    logic samp_q;
    logic filt_q;
    logic step;

    assign step = use_tick ? tick : 1'b1;
    assign filt = en ? filt_q : raw;

    // Sample and filter state: tracks the input while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            samp_q <= raw;
            filt_q <= raw;
        end else if (step) begin
            samp_q <= raw;
            if (raw == samp_q)
                filt_q <= raw;
        end
    end

    // R4: an enabled pin holds its level between sample points
    a_r4_hold_off_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step) |=> $stable(filt_q));
    // R3: disagreeing samples never move the filtered level
    a_r3_need_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && (raw != samp_q)) |=> $stable(filt_q));
endmodule

// File: rtl/pin_debounce_bank.sv
// Debounce bank top: configuration store, shared tick divider and one
// filter per pin. Inputs are assumed to be synchronous to clk.
module pin_debounce_bank #(
    parameter int NUM_PINS = 32,
    parameter int DIV_W    = 24,
    parameter int ADDR_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [pdb_pkg::WDATA_W-1:0] cfg_wdata,
    input  logic [NUM_PINS-1:0]         pin_raw,
    output logic [NUM_PINS-1:0]         pin_filt
);
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] sel_q;
    logic [DIV_W-1:0]    div_q;
    logic                div_wr;
    logic                tick;

    pdb_cfg_regs #(
        .NUM_PINS (NUM_PINS),
        .DIV_W    (DIV_W),
        .ADDR_W   (ADDR_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .en_q   (en_q),
        .sel_q  (sel_q),
        .div_q  (div_q),
        .div_wr (div_wr)
    );

    pdb_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_q),
        .restart (div_wr),
        .tick    (tick)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pdb_pin_filter u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (pin_raw[p]),
            .en       (en_q[p]),
            .use_tick (sel_q[p]),
            .tick     (tick),
            .filt     (pin_filt[p])
        );
    end

    // R9: reset leaves every pin unfiltered
    a_r9_reset_cfg: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && sel_q == '0 && div_q == '0));
endmodule

// File: tb/test_pin_debounce_bank.sv
// Self-checking bench: directed timing checks plus a random sweep against
// a cycle model written from the requirements.
module test_pin_debounce_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] pin_filt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pin_debounce_bank i_pin_debounce_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pin_raw(pin_raw), .pin_filt(pin_filt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Requirement model state
    logic [NP-1:0] m_en, m_sel, m_samp, m_filt;
    longint m_div, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_sel = '0; m_div = 0; m_cnt = 0;
            m_samp = pin_raw; m_filt = pin_raw;
        end else begin
            bit tk, rs;
            tk = (m_cnt == 2*(m_div+1)-1);
            rs = 0;
            for (int i = 0; i < NP; i++) begin
                if (!m_en[i]) begin
                    m_samp[i] = pin_raw[i]; m_filt[i] = pin_raw[i];
                end else if (!m_sel[i] || tk) begin
                    if (pin_raw[i] == m_samp[i]) m_filt[i] = pin_raw[i];
                    m_samp[i] = pin_raw[i];
                end
            end
            if (cfg_we) begin
                for (int b = 0; b < 16; b++) begin
                    if (cfg_wdata[16+b]) begin
                        if (cfg_addr < 2) m_en[16*cfg_addr[0]+b] = cfg_wdata[b];
                        else if (cfg_addr < 4) m_sel[16*cfg_addr[0]+b] = cfg_wdata[b];
                    end
                end
                if (cfg_addr == 4) begin m_div = cfg_wdata[23:0]; rs = 1; end
            end
            m_cnt = (rs || tk) ? 0 : m_cnt + 1;
        end
    end

    function automatic logic [NP-1:0] model_out();
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) r[i] = m_en[i] ? m_filt[i] : pin_raw[i];
        return r;
    endfunction

    task automatic chk(string tag, logic [NP-1:0] got, logic [NP-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance one edge and compare against the model.
    task automatic step(string tag);
        @(posedge clk); @(negedge clk);
        chk(tag, pin_filt, model_out());
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step("cfg");
        cfg_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] old_v, new_v;
        // R1: output equals input through reset
        pin_raw = 32'hA5A5_0F0F;
        repeat (3) begin
            @(negedge clk);
            chk("R1", pin_filt, 32'hA5A5_0F0F);
        end
        rst_n = 1'b1;
        step("R1");
        chk("R1", pin_filt, 32'hA5A5_0F0F);
        // R9/R2: nothing enabled, so input passes with no delay
        pin_raw = 32'h1234_5678; #1;
        chk("R9", pin_filt, 32'h1234_5678);
        pin_raw = 32'hFFFF_0000; #1;
        chk("R2", pin_filt, 32'hFFFF_0000);
        // R6: zero mask changes nothing
        wr(3'd0, 32'h0000_FFFF);
        wr(3'd1, 32'h0000_FFFF);
        pin_raw = 32'h0F0F_F0F0; #1;
        chk("R6", pin_filt, 32'h0F0F_F0F0);
        // R6: partial mask enables pins 1,3,5,7 only
        wr(3'd0, 32'h00FF_00AA);
        pin_raw = 32'h0F0F_F00F; #1;
        chk("R6", pin_filt, 32'h0F0F_F0F0 & 32'h0000_00AA | 32'h0F0F_F00F & ~32'h0000_00AA);
        step("R6");
        chk("R6", pin_filt, model_out());
        step("R6");
        chk("R6", pin_filt, 32'h0F0F_F00F);
        // R3: all pins on the raw clock
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        repeat (3) step("R3");
        old_v = pin_raw; new_v = ~old_v;
        pin_raw = new_v; #1;
        chk("R3", pin_filt, old_v);
        step("R3"); chk("R3", pin_filt, old_v);
        step("R3"); chk("R3", pin_filt, new_v);
        // R3: a one-edge glitch is dropped
        pin_raw = old_v;
        step("R3");
        pin_raw = new_v;
        step("R3"); chk("R3", pin_filt, new_v);
        step("R3"); chk("R3", pin_filt, new_v);
        // R4/R5/R7: tick timing after a divider write, junk in upper bits
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        for (int d = 0; d < 4; d++) begin
            repeat (4*(d+1)+2) step("R4");
            old_v = pin_raw; new_v = old_v ^ 32'h5A5A_C3C3;
            wr(3'd4, {8'(8'h3C + d*17), 24'(d)});
            pin_raw = new_v;
            for (int k = 1; k < 4*(d+1); k++) begin
                step("R5");
                chk("R4", pin_filt, old_v);
            end
            step("R4");
            chk("R7", pin_filt, new_v);
        end
        // R8: low half on the tick, high half on the raw clock
        wr(3'd3, 32'hFFFF_0000);
        wr(3'd4, 32'h0000_0002);
        for (int c = 0; c < 400; c++) begin
            if ($urandom_range(0, 3) == 0) pin_raw = $urandom;
            else if ($urandom_range(0, 1) == 0) pin_raw = pin_raw ^ (32'h1 << $urandom_range(0, 31));
            step("R8");
        end
        // R4/R5/R6: random reconfiguration and divider rewrites at any phase
        for (int c = 0; c < 3000; c++) begin
            int pick;
            pick = $urandom_range(0, 19);
            if (pick == 0) wr(3'($urandom_range(0, 3)), $urandom);
            else if (pick == 1) wr(3'd4, {$urandom_range(0, 255), 24'($urandom_range(0, 5))} );
            else begin
                if ($urandom_range(0, 2) == 0) pin_raw = $urandom;
                step("R4");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule